// File: doc/BRIEF.md
# Conditional add execution unit

This unit decodes and executes one predicated add instruction. Three encodings are accepted: a 32-bit register-register form, a 32-bit register-immediate form with a signed 9-bit constant, and a 16-bit short form. The short form adds a signed 4-bit constant to a register in place. A condition register is read from an external 16-entry, 32-bit register file. When that register holds any non-zero value, the first source operand plus the second operand is produced. When it is zero, the first source operand passes through unchanged.

The register file sits outside the unit. The unit drives three combinational read addresses and takes the read data back. It raises a write strobe, a write address and write data in the same cycle as an accepted instruction. Four overflow status bits are kept in an internal status register: overflow, sticky overflow, advanced overflow and sticky advanced overflow. They change only when the condition holds. A 32-bit word that is not one of the two long encodings is flagged as illegal and has no effect.

Top module: `cadd_exec_unit`

## Requirements
- R1: Register-register form: bits 7:0 = 0x2B, bits 23:20 = 0, destination c in 31:28, condition d in 27:24, source b in 15:12, source a in 11:8, bits 19:16 ignored. When D[d] != 0, D[a] + D[b] is written to D[c].
- R2: Register-immediate form: bits 7:0 = 0xAB, bits 23:21 = 0, and a 9-bit constant in bits 20:12, sign-extended to 32 bits. The c, d and a fields are as in R1. When D[d] != 0, D[a] + constant is written to D[c].
- R3: In either long form, when D[d] == 0, D[a] is written unchanged to D[c].
- R4: With the short-form select high, only bits 15:0 are used: a signed 4-bit constant in bits 15:12 and register a in bits 11:8, with bits 7:0 ignored. The condition register is always D[15]. When D[15] != 0, D[a] + constant is written to D[a]; otherwise no write occurs.
- R5: The written result is the low 32 bits of the sum, wrapping without saturation.
- R6: When the condition holds, overflow V becomes 1 exactly when the signed sum exceeds 0x7FFFFFFF or falls below -0x80000000, and 0 otherwise.
- R7: Sticky overflow SV is set when the condition and overflow are both true and is never cleared by an instruction.
- R8: When the condition holds, advanced overflow AV becomes result bit 31 XOR result bit 30.
- R9: Sticky advanced overflow SAV is set when the condition and AV are both true and is never cleared by an instruction.
- R10: All four flags hold their values when the condition is false or no instruction is presented.
- R11: A long-form word with a wrong primary or secondary opcode raises the illegal output, writes no register and changes no flag.
- R12: The register write is presented combinationally in the cycle the valid strobe is high. The flags show the update after that cycle's rising clock edge. Reset clears all four flags, and no write occurs without the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| short_sel_i | input | 1 | Interpret bits 15:0 as the 16-bit short form |
| instr_i | input | 32 | Instruction word |
| rf_addr_a_o | output | 4 | Read address for first source |
| rf_addr_b_o | output | 4 | Read address for second source register |
| rf_addr_d_o | output | 4 | Read address for condition register |
| rf_data_a_i | input | 32 | Read data, first source |
| rf_data_b_i | input | 32 | Read data, second source |
| rf_data_d_i | input | 32 | Read data, condition register |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 4 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| illegal_o | output | 1 | Valid long-form word not recognised |
| flag_v_o | output | 1 | Overflow flag |
| flag_sv_o | output | 1 | Sticky overflow flag |
| flag_av_o | output | 1 | Advanced overflow flag |
| flag_sav_o | output | 1 | Sticky advanced overflow flag |

## Verification
The embedded properties assume that the register file returns read data combinationally for the addresses the unit drives in the same cycle, and that the short-form select is meaningful only while the valid strobe is high. The bench keeps within these assumptions with a behavioural register file. That file answers reads at once and takes writes on the clock edge. The bench changes instructions and register contents only at the falling edge. Register indices in each vector are chosen so that the a, b and d operands never alias, so that each preloaded value reaches the port it is meant for.

// File: rtl/cadd_pkg.sv
package cadd_pkg;

  localparam logic [7:0] OPC_RR = 8'h2B;
  localparam logic [7:0] OPC_RI = 8'h AB;

  typedef struct packed {
    logic v;
    logic sv;
    logic av;
    logic sav;
  } cadd_flags_t;

endpackage

// File: rtl/cadd_decode.sv
module cadd_decode #(
  parameter int XLEN = 32,
  parameter int RAW  = 4
) (
  input  logic [31:0]     instr,
  input  logic            short_sel,
  output logic [RAW-1:0]  a_idx,
  output logic [RAW-1:0]  b_idx,
  output logic [RAW-1:0]  d_idx,
  output logic [RAW-1:0]  c_idx,
  output logic            use_imm,
  output logic [XLEN-1:0] imm,
  output logic            is_short,
  output logic            legal
);
  import cadd_pkg::*;

  localparam int K9W = 9;
  localparam int K4W = 4;
  localparam logic [RAW-1:0] SHORT_COND = '1;

  logic [7:0]     opc;
  logic           rr_hit;
  logic           ri_hit;
  logic [XLEN-1:0] k9_ext;
  logic [XLEN-1:0] k4_ext;
  logic           unused_bits;

  assign opc    = instr[7:0];
  assign rr_hit = (opc == OPC_RR) && (instr[23:20] == 4'h0);
  assign ri_hit = (opc == OPC_RI) && (instr[23:21] == 3'h0);
  assign k9_ext = {{(XLEN-K9W){instr[20]}}, instr[20:12]};
  assign k4_ext = {{(XLEN-K4W){instr[15]}}, instr[15:12]};
  assign unused_bits = ^instr[19:16];

  always_comb begin
    is_short = short_sel;
    a_idx    = instr[8 +: RAW];
    b_idx    = instr[12 +: RAW];
    c_idx    = instr[28 +: RAW];
    if (short_sel) begin
      d_idx   = SHORT_COND;
      use_imm = 1'b1;
      imm     = k4_ext;
      legal   = 1'b1;
    end else begin
      d_idx   = instr[24 +: RAW];
      use_imm = ri_hit;
      imm     = k9_ext;
      legal   = rr_hit | ri_hit;
    end
  end

endmodule

// File: rtl/cadd_alu.sv
module cadd_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_val,
  input  logic [XLEN-1:0] op2,
  input  logic [XLEN-1:0] d_val,
  output logic            cond,
  output logic [XLEN-1:0] result,
  output logic            ovf,
  output logic            adv
);
  localparam int SW = XLEN + 1;

  logic [SW-1:0] sum_ext;

  assign cond    = |d_val;
  assign sum_ext = {a_val[XLEN-1], a_val} + {op2[XLEN-1], op2};

  always_comb begin
    result = cond ? sum_ext[XLEN-1:0] : a_val;
    ovf    = sum_ext[SW-1] ^ sum_ext[SW-2];
    adv    = result[XLEN-1] ^ result[XLEN-2];
  end

endmodule

// File: rtl/cadd_status.sv
module cadd_status (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic                  ovf,
  input  logic                  adv,
  output cadd_pkg::cadd_flags_t q
);
  import cadd_pkg::*;

  cadd_flags_t d;

  always_comb begin
    d = q;
    if (upd) begin
      d.v   = ovf;
      d.av  = adv;
      d.sv  = q.sv  | ovf;
      d.sav = q.sav | adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd) begin
      q <= d;
    end
  end

  AST_SV_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) $past(q.sv)  |-> q.sv);  // R7
  AST_SAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(q.sav) |-> q.sav); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !upd |=> $stable(q));     // R10

endmodule

// File: rtl/cadd_exec_unit.sv
module cadd_exec_unit #(
  parameter int XLEN = 32,
  parameter int RAW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid_i,
  input  logic            short_sel_i,
  input  logic [31:0]     instr_i,
  output logic [RAW-1:0]  rf_addr_a_o,
  output logic [RAW-1:0]  rf_addr_b_o,
  output logic [RAW-1:0]  rf_addr_d_o,
  input  logic [XLEN-1:0] rf_data_a_i,
  input  logic [XLEN-1:0] rf_data_b_i,
  input  logic [XLEN-1:0] rf_data_d_i,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            illegal_o,
  output logic            flag_v_o,
  output logic            flag_sv_o,
  output logic            flag_av_o,
  output logic            flag_sav_o
);
  import cadd_pkg::*;

  logic [RAW-1:0]  c_idx;
  logic            use_imm;
  logic [XLEN-1:0] imm;
  logic            is_short;
  logic            legal;
  logic [XLEN-1:0] op2;
  logic            cond;
  logic [XLEN-1:0] result;
  logic            ovf;
  logic            adv;
  logic            accept;
  logic            upd;
  cadd_flags_t     flags;

  cadd_decode #(.XLEN(XLEN), .RAW(RAW)) u_dec (
    .instr     (instr_i),
    .short_sel (short_sel_i),
    .a_idx     (rf_addr_a_o),
    .b_idx     (rf_addr_b_o),
    .d_idx     (rf_addr_d_o),
    .c_idx     (c_idx),
    .use_imm   (use_imm),
    .imm       (imm),
    .is_short  (is_short),
    .legal     (legal)
  );

  assign op2 = use_imm ? imm : rf_data_b_i;

  cadd_alu #(.XLEN(XLEN)) u_alu (
    .a_val  (rf_data_a_i),
    .op2    (op2),
    .d_val  (rf_data_d_i),
    .cond   (cond),
    .result (result),
    .ovf    (ovf),
    .adv    (adv)
  );

  assign accept     = instr_valid_i & legal;
  assign upd        = accept & cond;
  assign illegal_o  = instr_valid_i & ~legal;
  assign rf_we_o    = accept & (cond | ~is_short);
  assign rf_waddr_o = is_short ? rf_addr_a_o : c_idx;
  assign rf_wdata_o = result;

  cadd_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .ovf   (ovf),
    .adv   (adv),
    .q     (flags)
  );

  assign flag_v_o   = flags.v;
  assign flag_sv_o  = flags.sv;
  assign flag_av_o  = flags.av;
  assign flag_sav_o = flags.sav;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal_o |-> !rf_we_o); // R11
  AST_PASS_THROUGH:  assert property (@(posedge clk) disable iff (!rst_n)
                       (rf_we_o && rf_data_d_i == '0) |-> rf_wdata_o == rf_data_a_i); // R3
  AST_SHORT_COND:    assert property (@(posedge clk) disable iff (!rst_n)
                       (instr_valid_i && short_sel_i) |-> rf_addr_d_o == {RAW{1'b1}}); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !instr_valid_i |-> !rf_we_o); // R12
  AST_V_SETS_SV:     assert property (@(posedge clk) disable iff (!rst_n) flag_v_o |-> flag_sv_o); // R7

endmodule

// File: tb/cadd_exec_unit_tb.sv
`timescale 1ns/1ps
module cadd_exec_unit_tb_top;

  localparam time CLK_P = 20ns;

  typedef struct packed {
    logic        sh;
    logic [31:0] ins;
    logic [3:0]  ai;
    logic [3:0]  bi;
    logic [3:0]  di;
    logic [31:0] av;
    logic [31:0] bv;
    logic [31:0] dv;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic        ill;
    logic        v;
    logic        avf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h3400212B, 4'd1, 4'd2, 4'd4, 32'd5,        32'd7,        32'd1,        1'b1, 4'd3, 32'd12,       1'b0, 1'b0, 1'b0}, // R1
    '{1'b0, 32'h3400212B, 4'd1, 4'd2, 4'd4, 32'd5,        32'd7,        32'd0,        1'b1, 4'd3, 32'd5,        1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 32'h3400212B, 4'd1, 4'd2, 4'd4, 32'h7FFFFFFF, 32'd1,        32'd9,        1'b1, 4'd3, 32'h80000000, 1'b0, 1'b1, 1'b1}, // R5 R6
    '{1'b0, 32'h3400212B, 4'd1, 4'd2, 4'd4, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1, 4'd3, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1}, // R5 R6
    '{1'b0, 32'h3400212B, 4'd1, 4'd2, 4'd4, 32'h40000000, 32'd0,        32'd1,        1'b1, 4'd3, 32'h40000000, 1'b0, 1'b0, 1'b1}, // R8
    '{1'b0, 32'h671FF5AB, 4'd5, 4'd0, 4'd7, 32'd10,       32'd0,        32'd1,        1'b1, 4'd6, 32'd9,        1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 32'h670FF5AB, 4'd5, 4'd0, 4'd7, 32'd1,        32'd0,        32'd1,        1'b1, 4'd6, 32'd256,      1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 32'h671005AB, 4'd5, 4'd0, 4'd7, 32'd0,        32'd0,        32'd1,        1'b1, 4'd6, 32'hFFFFFF00, 1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 32'h671FF5AB, 4'd5, 4'd0, 4'd7, 32'h1234,     32'd0,        32'd0,        1'b1, 4'd6, 32'h1234,     1'b0, 1'b0, 1'b0}, // R3
    '{1'b1, 32'h0000F300, 4'd3, 4'd0, 4'd15,32'd100,      32'd0,        32'd1,        1'b1, 4'd3, 32'd99,       1'b0, 1'b0, 1'b0}, // R4
    '{1'b1, 32'h00007200, 4'd2, 4'd0, 4'd15,32'h7FFFFFFC, 32'd0,        32'd1,        1'b1, 4'd2, 32'h80000003, 1'b0, 1'b1, 1'b1}, // R4 R6
    '{1'b1, 32'h0000F300, 4'd3, 4'd0, 4'd15,32'd100,      32'd0,        32'd0,        1'b0, 4'd3, 32'd0,        1'b0, 1'b0, 1'b0}, // R4
    '{1'b0, 32'h3400212C, 4'd1, 4'd2, 4'd4, 32'd5,        32'd7,        32'd1,        1'b0, 4'd3, 32'd0,        1'b1, 1'b0, 1'b0}, // R11
    '{1'b0, 32'h3410212B, 4'd1, 4'd2, 4'd4, 32'd5,        32'd7,        32'd1,        1'b0, 4'd3, 32'd0,        1'b1, 1'b0, 1'b0}, // R11
    '{1'b0, 32'h672FF5AB, 4'd5, 4'd0, 4'd7, 32'd1,        32'd0,        32'd1,        1'b0, 4'd6, 32'd0,        1'b1, 1'b0, 1'b0}, // R11
    '{1'b1, 32'hFFFFF3AB, 4'd3, 4'd0, 4'd15,32'h10,       32'd0,        32'd2,        1'b1, 4'd3, 32'hF,        1'b0, 1'b0, 1'b0}  // R4
  };

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic        short_sel;
  logic [31:0] instr;
  logic [3:0]  ra, rb, rd;
  logic        we, ill;
  logic [3:0]  wa;
  logic [31:0] wd;
  logic        fv, fsv, fav, fsav;
  logic [31:0] rf [16];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  cadd_exec_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid_i (instr_valid),
    .short_sel_i   (short_sel),
    .instr_i       (instr),
    .rf_addr_a_o   (ra),
    .rf_addr_b_o   (rb),
    .rf_addr_d_o   (rd),
    .rf_data_a_i   (rf[ra]),
    .rf_data_b_i   (rf[rb]),
    .rf_data_d_i   (rf[rd]),
    .rf_we_o       (we),
    .rf_waddr_o    (wa),
    .rf_wdata_o    (wd),
    .illegal_o     (ill),
    .flag_v_o      (fv),
    .flag_sv_o     (fsv),
    .flag_av_o     (fav),
    .flag_sav_o    (fsav)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (we) rf[wa] <= wd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_flags(input logic v, input logic sv, input logic av, input logic sav, input string req);
    chk({fv, fsv, fav, fsav} === {v, sv, av, sav}, req,
        {28'd0, fv, fsv, fav, fsav}, {28'd0, v, sv, av, sav});
  endtask

  // load operands, present instruction, check the write port, clock it in
  task automatic apply(input vec_t x, input string req);
    @(negedge clk);
    rf[x.bi] = x.bv;
    rf[x.di] = x.dv;
    rf[x.ai] = x.av;
    short_sel = x.sh;
    instr = x.ins;
    instr_valid = 1'b1;
    #1;
    chk(we === x.we, req, {31'd0, we}, {31'd0, x.we});
    chk(ill === x.ill, req, {31'd0, ill}, {31'd0, x.ill});
    if (x.we) begin
      chk(wa === x.wa, req, {28'd0, wa}, {28'd0, x.wa});
      chk(wd === x.wd, req, wd, x.wd);
    end
    @(negedge clk);
    instr_valid = 1'b0;
    if (x.we) chk(rf[x.wa] === x.wd, "R12", rf[x.wa], x.wd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0;
    short_sel = 1'b0;
    instr = '0;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    do_reset();
    chk_flags(0, 0, 0, 0, "R12");

    for (int i = 0; i < NV; i++) begin
      do_reset();
      apply(VECS[i], $sformatf("vec%0d R1 R2 R3 R4 R5 R11", i));
      chk_flags(VECS[i].v, VECS[i].v, VECS[i].avf, VECS[i].avf,
                $sformatf("vec%0d R6 R7 R8 R9 R10", i));
    end

    // sticky flags survive a clean add
    do_reset();
    apply(VECS[2], "R6");
    chk_flags(1, 1, 1, 1, "R6 R8");
    apply(VECS[0], "R1");
    chk_flags(0, 1, 0, 1, "R7 R9");
    // condition false holds everything
    apply(VECS[2], "R1");
    apply(VECS[1], "R3");
    chk_flags(1, 1, 1, 1, "R10");
    // illegal word with a true condition changes nothing
    apply(VECS[4], "R8");
    chk_flags(0, 1, 1, 1, "R8");
    apply(VECS[13], "R11");
    chk_flags(0, 1, 1, 1, "R11");
    // short form with false condition holds flags
    apply(VECS[11], "R4");
    chk_flags(0, 1, 1, 1, "R10");
    // no valid strobe: no write even with a decodable word
    @(negedge clk);
    rf[4] = 32'd1;
    instr = 32'h3400212B;
    short_sel = 1'b0;
    instr_valid = 1'b0;
    #1;
    chk(we === 1'b0, "R12", {31'd0, we}, 32'd0);
    @(negedge clk);
    chk_flags(0, 1, 1, 1, "R10");
    // reset clears
    do_reset();
    chk_flags(0, 0, 0, 0, "R12");

    finish_run();
  end

endmodule